// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets a host reach the management registers of an external Ethernet PHY over the two-wire MDC/MDIO management bus. All control goes through one 32-bit command/status word. A host write that sets the read or the write operation bit starts a Clause-22 management transaction. The block sends a preamble of 32 ones and then the frame, one bit per MDC period. For a read it releases the data line through a separate output enable so that the PHY can answer, then shifts in the turnaround and data bits.

When the last MDC period ends, the word shows ready. For a read, the 16 sampled data bits appear in the low half of the word. An error flag reports a PHY that did not drive the second turnaround bit low. If the host set the interrupt-enable bit in the command, completion also raises an interrupt line.

The MDC half-period is a parameter counted in system clocks. Any command written while a transaction is running is dropped.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0 and `mdc`, `mdio_oe` and `irq` are low. While no transaction runs, `mdc` and `mdio_oe` stay low.
- R2: Every frame begins with 32 MDC periods during which the block drives `mdio_o` high.
- R3: A read frame drives 14 bits after the preamble, MSB first: start 01, opcode 10, PHY address (command bits 25:21), then register address (command bits 20:16). The block then holds `mdio_oe` low for the remaining 18 periods, so it drives 46 periods in total.
- R4: A write frame drives all 32 bits after the preamble, MSB first: 01, 01, PHY address, register address, turnaround 10, then data (command bits 15:0). `mdio_oe` stays high for all 64 periods.
- R5: Each bit lasts one MDC period: HALF_DIV clocks low, then HALF_DIV clocks high. `mdio_o` and `mdio_oe` change only while MDC is low. Every frame has exactly 64 MDC rising edges.
- R6: At completion, ready (bit 28) is set and both operation bits (26 write, 27 read) read 0. After a read, bits 15:0 hold the 16 bits sampled at the last 16 MDC rising edges, first bit as MSB.
- R7: Error (bit 30) is set at the end of a read if `mdio_i` was high at the MDC rising edge of the second turnaround bit. A write always ends with error clear.
- R8: `irq` is high exactly when ready is set and the interrupt-enable bit (29) of the last accepted command was 1.
- R9: A command written while a transaction runs is ignored. The frame on the pins and the stored fields keep those of the running command.
- R10: A write with neither operation bit set does nothing while idle. A write with both operation bits set runs as a read.
- R11: Accepting a command clears ready and error. While the frame runs, the status word shows the requested operation bit and the PHY and register addresses, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word: data, addresses, op bits, interrupt enable |
| csr_rdata | output | 32 | Status word: fields, op-in-progress, ready, interrupt enable, error |
| irq | output | 1 | Completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the data pin (low = released) |
| mdio_i | input | 1 | Data pin as seen from the PHY side |

## Verification
The assertions check, on every cycle, that data and enable stay stable while MDC is high. They also check that the pins are quiet when idle, that ready and error stay clear while a transaction runs and ready rises at its end, that the addresses stay fixed during a frame, and that a write frame keeps the line driven. Only the bench scenarios can show the bit order of each frame, the count of driven periods, and the exact MDC timing. The same holds for the read data and error capture from a modelled PHY, and for the effect of ignored commands, since each of these needs the full serial history of a transaction.

// File: rtl/mdio_pkg.sv
// Package: shared constants, field positions and the frame builder for the
// management master. Assumes Clause-22 framing with a 32-bit preamble.
package mdio_pkg;
    localparam int CSR_W      = 32;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int REG_LSB    = 16;
    localparam int PHY_LSB    = 21;
    localparam int BIT_WR     = 26;
    localparam int BIT_RD     = 27;
    localparam int BIT_RDY    = 28;
    localparam int BIT_IE     = 29;
    localparam int BIT_ERR    = 30;

    localparam int PRE_BITS    = 32;
    localparam int BODY_BITS   = 32;
    localparam int FRAME_BITS  = PRE_BITS + BODY_BITS;
    localparam int HDR_BITS    = 14;
    localparam int TA_BITS     = 2;
    localparam int RX_BITS     = TA_BITS + DATA_W;
    localparam int RELEASE_IDX = PRE_BITS + HDR_BITS;
    localparam int TA2_IDX     = RELEASE_IDX + 1;
    localparam int IDX_W       = $clog2(FRAME_BITS);

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } mdio_req_t;

    // Builds the full serial image, preamble first, MSB sent first.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
        logic [BODY_BITS-1:0] body;
        if (r.rd)
            body = {SOF_CODE, OP_READ, r.phy, r.regad, {RX_BITS{1'b1}}};
        else
            body = {SOF_CODE, OP_WRITE, r.phy, r.regad, TA_DRIVE, r.data};
        return {{PRE_BITS{1'b1}}, body};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// Module: generates MDC from the system clock while a frame runs.
// Each bit period is HALF_DIV clocks low followed by HALF_DIV clocks high.
// Assumes HALF_DIV >= 1; MDC rests low whenever run is low.
module mdio_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             phase_end;

    // End of the current half-period.
    always_comb begin
        phase_end = run && (cnt_q == CNT_LAST);
        rise_evt  = phase_end && !mdc_q;
        fall_evt  = phase_end && mdc_q;
    end

    // Half-period counter and MDC level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (phase_end) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc = mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
// Module: transmit shift register (MSB out first) and receive shift register
// (bits enter at LSB). The receive register keeps only the last DATA_W bits,
// so the turnaround bits shift out of it.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  shift_out,
    input  logic                  shift_in,
    input  logic                  din,
    output logic                  tx_bit,
    output logic [DATA_W-1:0]     rx_word
);
    logic [FRAME_BITS-1:0] tx_q;
    logic [DATA_W-1:0]     rx_q;

    // Outgoing bit stream: loaded at start, advanced on each MDC fall.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_q <= '0;
        else if (load)      tx_q <= frame;
        else if (shift_out) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
    end

    // Incoming bits: captured at MDC rise while the line is released.
    always_ff @(posedge clk) begin
        if (!rst_n || load) rx_q <= '0;
        else if (shift_in)  rx_q <= {rx_q[DATA_W-2:0], din};
    end

    assign tx_bit  = tx_q[FRAME_BITS-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/mdio_bitseq.sv
// Module: counts bit periods, decides when the master drives or releases
// the data line, checks the second turnaround bit and flags the frame end.
module mdio_bitseq
    import mdio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic is_rd,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic din,
    output logic drive_en,
    output logic capture_en,
    output logic ta_err,
    output logic frame_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(RELEASE_IDX);
    localparam logic [IDX_W-1:0] TA2_POS  = IDX_W'(TA2_IDX);

    logic [IDX_W-1:0] idx_q;
    logic             released;
    logic             ta_err_q;

    // Line ownership and event qualification for the current bit.
    always_comb begin
        released   = is_rd && (idx_q >= REL_IDX);
        drive_en   = run && !released;
        capture_en = rise_evt && released;
        frame_done = fall_evt && (idx_q == LAST_IDX);
    end

    // Bit index: advances at the end of every bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || load)                     idx_q <= '0;
        else if (fall_evt && idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
    end

    // Turnaround check: the PHY must pull the line low on the second bit.
    always_ff @(posedge clk) begin
        if (!rst_n || load) ta_err_q <= 1'b0;
        else if (rise_evt && is_rd && idx_q == TA2_POS && din) ta_err_q <= 1'b1;
    end

    assign ta_err = ta_err_q;
endmodule

// File: rtl/mdio_master.sv
// Module: top of the management master. Holds the command/status word,
// accepts a command only while idle, and gathers the result at frame end.
// Assumes mdio_i is already synchronous to clk or settles well inside a
// half-period.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CSR_W-1:0] cmd_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             irq,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic              busy_q, rd_q, ie_q, rdy_q, err_q;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] data_q;
    mdio_req_t         new_req;
    logic              start;
    logic              rise_evt, fall_evt;
    logic              tx_bit, drive_en, capture_en, ta_err, frame_done;
    logic [DATA_W-1:0] rx_word;
    logic              unused_wbits;

    // Decode a host write into a request and decide whether it starts.
    always_comb begin
        new_req.rd    = cmd_wdata[BIT_RD];
        new_req.phy   = cmd_wdata[PHY_LSB +: ADDR_W];
        new_req.regad = cmd_wdata[REG_LSB +: ADDR_W];
        new_req.data  = cmd_wdata[DATA_W-1:0];
        start = cmd_we && !busy_q && (cmd_wdata[BIT_RD] || cmd_wdata[BIT_WR]);
    end

    assign unused_wbits = ^{cmd_wdata[CSR_W-1], cmd_wdata[BIT_ERR], cmd_wdata[BIT_RDY]};

    // Command/status state: latch at start, publish result at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            ie_q   <= 1'b0;
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
            phy_q  <= '0;
            reg_q  <= '0;
            data_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rd_q   <= new_req.rd;
            ie_q   <= cmd_wdata[BIT_IE];
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
            phy_q  <= new_req.phy;
            reg_q  <= new_req.regad;
            data_q <= new_req.data;
        end else if (frame_done) begin
            busy_q <= 1'b0;
            rdy_q  <= 1'b1;
            if (rd_q) begin
                data_q <= rx_word;
                err_q  <= ta_err;
            end
        end
    end

    // Status word assembly.
    always_comb begin
        csr_rdata                       = '0;
        csr_rdata[DATA_W-1:0]           = data_q;
        csr_rdata[REG_LSB +: ADDR_W]    = reg_q;
        csr_rdata[PHY_LSB +: ADDR_W]    = phy_q;
        csr_rdata[BIT_WR]               = busy_q && !rd_q;
        csr_rdata[BIT_RD]               = busy_q && rd_q;
        csr_rdata[BIT_RDY]              = rdy_q;
        csr_rdata[BIT_IE]               = ie_q;
        csr_rdata[BIT_ERR]              = err_q;
    end

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .frame     (build_frame(new_req)),
        .shift_out (fall_evt),
        .shift_in  (capture_en),
        .din       (mdio_i),
        .tx_bit    (tx_bit),
        .rx_word   (rx_word)
    );

    mdio_bitseq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .run        (busy_q),
        .is_rd      (rd_q),
        .rise_evt   (rise_evt),
        .fall_evt   (fall_evt),
        .din        (mdio_i),
        .drive_en   (drive_en),
        .capture_en (capture_en),
        .ta_err     (ta_err),
        .frame_done (frame_done)
    );

    // Pin outputs and interrupt.
    assign mdio_oe = drive_en;
    assign mdio_o  = tx_bit && drive_en;
    assign irq     = rdy_q && ie_q;
endmodule

// File: rtl/mdio_master_chk.sv
// Checker: cycle-level properties of the management master, bound to the top.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [BIT_ERR:REG_LSB] csr_ctl,
    input logic                 irq,
    input logic                 mdc,
    input logic                 mdio_o,
    input logic                 mdio_oe
);
    logic busy;
    assign busy = csr_ctl[BIT_WR] || csr_ctl[BIT_RD];

    // R5
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R11
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!csr_ctl[BIT_RDY] && !csr_ctl[BIT_ERR] && !irq));

    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_ctl[BIT_WR] |-> mdio_oe);

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(csr_ctl[BIT_WR-1:REG_LSB]));

    // R6
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> csr_ctl[BIT_RDY]);

    // R8
    irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr_ctl[BIT_RDY] && csr_ctl[BIT_IE]));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .csr_ctl (csr_rdata[mdio_pkg::BIT_ERR:mdio_pkg::REG_LSB]),
    .irq     (irq),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_tb_top.sv
// Bench: vector table of commands and PHY answers, then directed tests.
module mdio_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int NVEC       = 6;

    localparam logic [31:0] CMDS [NVEC] = '{
        32'h2420_A5C3, 32'h2BFF_0000, 32'h0802_0000,
        32'h0555_0000, 32'h28B0_0000, 32'h26AA_FFFF };
    localparam logic [15:0] RSPS [NVEC] = '{
        16'h0000, 16'h1234, 16'h8001, 16'h0000, 16'h5A5A, 16'h0000 };
    localparam logic TA2S [NVEC] = '{ 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .csr_rdata(csr_rdata), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    // PHY model: records the line at each MDC rise, answers reads on MDC fall.
    logic [63:0] cap = '0;
    int          nrise = 0;
    int          noe = 0;
    int          base_rise = 0;
    logic [17:0] resp = '1;
    time         t_rise = 0;
    time         per_last = 0;
    time         high_last = 0;

    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_o};
        if (mdio_oe) noe++;
        nrise++;
        per_last = $time - t_rise;
        t_rise = $time;
    end

    always @(negedge mdc) begin
        int k;
        high_last = $time - t_rise;
        k = nrise - base_rise - 46;
        if (k >= 0 && k < 18) mdio_i = resp[17-k];
        else                  mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        if (c[27])
            return {32'hFFFF_FFFF, 2'b01, 2'b10, c[25:21], c[20:16], 18'h3FFFF};
        else
            return {32'hFFFF_FFFF, 2'b01, 2'b01, c[25:21], c[20:16], 2'b10, c[15:0]};
    endfunction

    function automatic logic [31:0] exp_csr(input logic [31:0] c, input logic [15:0] r,
                                            input logic ta2);
        logic rd;
        rd = c[27];
        return {1'b0, rd & ta2, c[29], 1'b1, 2'b00, c[25:16], rd ? r : c[15:0]};
    endfunction

    task automatic issue(input logic [31:0] c);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = c;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!csr_rdata[28] && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(csr_rdata[28], "R6 ready after frame", {63'd0, csr_rdata[28]}, 64'd1);
    endtask

    // Checks the serial image, driven count, MDC timing and the result word.
    task automatic frame_checks(input logic [31:0] c, input logic [15:0] r, input logic ta2,
                                input int oe0, input int rise0);
        logic [63:0] ef;
        ef = exp_frame(c);
        check(cap[63:32] == 32'hFFFF_FFFF, "R2 preamble", {32'd0, cap[63:32]}, 64'hFFFF_FFFF);
        if (c[27]) begin
            check(cap[63:18] == ef[63:18], "R3 read header", {18'd0, cap[63:18]}, {18'd0, ef[63:18]});
            check(noe - oe0 == 46, "R3 driven periods", 64'(noe - oe0), 64'd46);
        end else begin
            check(cap == ef, "R4 write frame", cap, ef);
            check(noe - oe0 == 64, "R4 driven periods", 64'(noe - oe0), 64'd64);
        end
        check(nrise - rise0 == 64, "R5 MDC pulses", 64'(nrise - rise0), 64'd64);
        check(per_last == 2*HALF*CLK_PERIOD, "R5 MDC period", 64'(per_last), 64'(2*HALF*CLK_PERIOD));
        check(high_last == HALF*CLK_PERIOD, "R5 MDC high phase", 64'(high_last), 64'(HALF*CLK_PERIOD));
        check(csr_rdata == exp_csr(c, r, ta2), "R6 R7 status word", {32'd0, csr_rdata},
              {32'd0, exp_csr(c, r, ta2)});
        check(irq == c[29], "R8 irq follows enable", {63'd0, irq}, {63'd0, c[29]});
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        $display("FAIL R5 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        int oe0, rise0;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(csr_rdata == 32'd0, "R1 status after reset", {32'd0, csr_rdata}, 64'd0);
        check({mdc, mdio_oe, irq} == 3'b000, "R1 pins after reset", {61'd0, mdc, mdio_oe, irq}, 64'd0);

        // Vector table: one transaction per entry.
        for (int i = 0; i < NVEC; i++) begin
            resp = {1'b1, TA2S[i], RSPS[i]};
            base_rise = nrise;
            oe0 = noe;
            rise0 = nrise;
            issue(CMDS[i]);
            wait_done();
            repeat (2) @(negedge clk);
            frame_checks(CMDS[i], RSPS[i], TA2S[i], oe0, rise0);
        end

        // R9 / R11: second command while busy is dropped.
        resp = '1;
        base_rise = nrise;
        oe0 = noe;
        rise0 = nrise;
        issue(32'h0464_1357);
        repeat (20) @(negedge clk);
        check(!csr_rdata[28] && !csr_rdata[30] && csr_rdata[26] && !irq, "R11 busy status",
              {32'd0, csr_rdata}, 64'h0464_1357);
        issue(32'h2BFF_0000);
        wait_done();
        repeat (2) @(negedge clk);
        check(cap == exp_frame(32'h0464_1357), "R9 frame of first command", cap,
              exp_frame(32'h0464_1357));
        check(csr_rdata == exp_csr(32'h0464_1357, 16'h0, 1'b0), "R9 fields kept",
              {32'd0, csr_rdata}, {32'd0, exp_csr(32'h0464_1357, 16'h0, 1'b0)});
        check(noe - oe0 == 64 && nrise - rise0 == 64, "R9 single frame only",
              64'(nrise - rise0), 64'd64);

        // R10: write without op bits does nothing.
        snap = csr_rdata;
        rise0 = nrise;
        issue(32'h23FF_FFFF);
        repeat (40) @(negedge clk);
        check(csr_rdata == snap, "R10 no-op write ignored", {32'd0, csr_rdata}, {32'd0, snap});
        check(nrise == rise0 && !mdc && !mdio_oe, "R10 no frame started",
              64'(nrise - rise0), 64'd0);

        // R10: both op bits run as a read.
        resp = {1'b1, 1'b0, 16'hBEEF};
        base_rise = nrise;
        oe0 = noe;
        rise0 = nrise;
        issue(32'h0C22_0000);
        wait_done();
        repeat (2) @(negedge clk);
        check(cap[63:18] == exp_frame(32'h0822_0000) >> 18, "R10 both bits give read header",
              {18'd0, cap[63:18]}, exp_frame(32'h0822_0000) >> 18);
        check(noe - oe0 == 46, "R10 both bits release line", 64'(noe - oe0), 64'd46);
        check(csr_rdata[15:0] == 16'hBEEF && !csr_rdata[30], "R10 R6 read data",
              {48'd0, csr_rdata[15:0]}, 64'hBEEF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule